// File: doc/BRIEF.md
# Ping-Pong DMA Address Sequencer

This block produces the read addresses of an audio stream that alternates between two memory areas. Each area is described by a 32-bit start address and a 16-bit byte length. On every sample tick, while running, the sequencer emits one address: the active area's start plus the current offset. It then advances the offset by the sample size in bytes. The sample size is 1, 2 or 4 bytes, chosen by the format bits. When an area is used up, the block raises that area's finished flag, returns the offset to zero and moves to the other area. Areas therefore alternate first, second, first, and so on.

Software programs the areas and the control word through a simple word-indexed register port. The same port reads the current position and the in-area offset, and acknowledges finished flags by writing ones back. Clearing the run bit pauses the stream in place. Setting it again resumes from the held area and offset. Addresses leave through a one-entry valid/ready output. An address stays presented, unchanged, until the consumer takes it. A tick that arrives while that entry is still held is dropped, and the position does not advance. A new address can be loaded in the same cycle the old one is accepted.

Register indices on `reg_addr`: 0 control, 1 status, 2 first-area start, 3 second-area start, 4 lengths, 5 current position, 6 offset. Index 4 carries the first-area length in bits 15:0 and the second-area length in bits 31:16. Writes to indices 5 and 6 are ignored.

Top module: `pingpong_addr_seq`

## Requirements
- R1: After reset every register reads zero, `addr_valid` is 0 and `irq` is 0.
- R2: When control bit 0 is set, `tick` is high and the output entry is empty or being accepted, the next cycle shows `addr_valid`=1 with `addr_out` equal to the active area's start plus the offset held before that tick.
- R3: While control bit 0 is 0, ticks issue no address and the area and offset hold. After bit 0 is set again, the stream continues from the held area and offset.
- R4: The offset advances per issued address by 1 byte when control bits 5:4 are 00, by 2 bytes when they are 01 (bit 4 = 16-bit samples), and by 4 bytes when they are 11. The value 10 (bit 5 only, two channels of 8-bit samples) also gives 2 bytes.
- R5: If the offset plus the step is at least the active length, the issued address is the last one of the area. The offset then becomes 0, the active area switches, and the finished flag of the area just left is set: status bit 1 for the first area, status bit 2 for the second. The first active area after reset is the first area.
- R6: While `addr_valid`=1 and `addr_ready`=0, `addr_valid` stays 1 and `addr_out` is stable. Ticks in that state are dropped and the offset does not advance.
- R7: Writing status with a 1 in bit 1 or bit 2 clears that flag, and a 0 leaves it alone. Writing 0xFFFF clears both flags. A flag being set in the same cycle as its clear ends up set.
- R8: `irq` is high exactly when at least one finished flag is set.
- R9: Control bits 31:6 always read 0. Status bits other than 1 and 2 always read 0, whatever is written.
- R10: Index 5 reads the active area's start plus the offset. Index 6 reads the offset in bits 15:0 and the active area in bit 16 (0 first, 1 second).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick | input | 1 | Sample clock tick |
| addr_valid | output | 1 | Output address valid |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_out | output | 32 | Read address |
| irq | output | 1 | Any finished flag set |

## Verification
A wrong offset or active area shows up at once at `addr_out`, on the next issued address. It also shows in the position and offset registers in the same cycle. A wrong wrap decision appears within one area length of ticks: as a missing or early flag, a wrong `irq`, or an address from the wrong area. A handshake error shows up at the next stall, as an address that changes under back-pressure or a tick that is not dropped.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL   = 3'd0,
    IDX_STATUS = 3'd1,
    IDX_STARTA = 3'd2,
    IDX_STARTB = 3'd3,
    IDX_LENS   = 3'd4,
    IDX_POS    = 3'd5,
    IDX_OFS    = 3'd6
  } reg_idx_e;

  localparam int CTRL_BITS = 6;
  localparam int RUN_BIT   = 0;
  localparam int WIDE_BIT  = 4;
  localparam int STEREO_BIT = 5;
endpackage

// File: rtl/pps_seq.sv
module pps_seq
  import pps_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [2:0]    step,
  input  logic [AW-1:0] start_a,
  input  logic [AW-1:0] start_b,
  input  logic [LW-1:0] len_a,
  input  logic [LW-1:0] len_b,
  input  logic          tick,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    done,
  output logic          active,
  output logic [LW-1:0] offset,
  output logic [AW-1:0] position
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic          act_q;
  logic [LW-1:0] ofs_q;
  logic          fire;
  logic          wrap;
  logic [LW:0]   next_sum;
  logic [LW-1:0] cur_len;
  logic [AW-1:0] cur_base;

  assign cur_base = act_q ? start_b : start_a;
  assign cur_len  = act_q ? len_b : len_a;
  assign next_sum = {1'b0, ofs_q} + {{(LW-2){1'b0}}, step};
  assign wrap     = next_sum >= {1'b0, cur_len};
  assign fire     = tick && run && (!valid_q || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      act_q   <= 1'b0;
      ofs_q   <= '0;
    end else begin
      if (valid_q && out_ready) valid_q <= 1'b0;
      if (fire) begin
        valid_q <= 1'b1;
        addr_q  <= cur_base + {{(AW-LW){1'b0}}, ofs_q};
        if (wrap) begin
          ofs_q <= '0;
          act_q <= ~act_q;
        end else begin
          ofs_q <= next_sum[LW-1:0];
        end
      end
    end
  end

  assign done[0]   = fire && wrap && !act_q;
  assign done[1]   = fire && wrap && act_q;
  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign active    = act_q;
  assign offset    = ofs_q;
  assign position  = cur_base + {{(AW-LW){1'b0}}, ofs_q};
endmodule

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [1:0]       done,
  input  logic             active,
  input  logic [LW-1:0]    offset,
  input  logic [AW-1:0]    position,
  output logic             run,
  output logic [2:0]       step,
  output logic [AW-1:0]    start_a,
  output logic [AW-1:0]    start_b,
  output logic [LW-1:0]    len_a,
  output logic [LW-1:0]    len_b,
  output logic [1:0]       flags
);
  logic [CTRL_BITS-1:0] ctrl_q;
  logic [1:0]           flag_q;
  logic [1:0]           ack;

  assign ack = (wr && idx == IDX_STATUS) ? wdata[2:1] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flag_q  <= '0;
      start_a <= '0;
      start_b <= '0;
      len_a   <= '0;
      len_b   <= '0;
    end else begin
      flag_q <= (flag_q & ~ack) | done;
      if (wr) begin
        case (idx)
          IDX_CTRL:   ctrl_q  <= wdata[CTRL_BITS-1:0];
          IDX_STARTA: start_a <= wdata[AW-1:0];
          IDX_STARTB: start_b <= wdata[AW-1:0];
          IDX_LENS: begin
            len_a <= wdata[LW-1:0];
            len_b <= wdata[2*LW-1:LW];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case ({ctrl_q[STEREO_BIT], ctrl_q[WIDE_BIT]})
      2'b00:   step = 3'd1;
      2'b11:   step = 3'd4;
      default: step = 3'd2;
    endcase
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_CTRL:   rdata[CTRL_BITS-1:0] = ctrl_q;
      IDX_STATUS: rdata[2:1] = flag_q;
      IDX_STARTA: rdata[AW-1:0] = start_a;
      IDX_STARTB: rdata[AW-1:0] = start_b;
      IDX_LENS:   rdata = {len_b, len_a};
      IDX_POS:    rdata[AW-1:0] = position;
      IDX_OFS:    rdata = {15'd0, active, offset};
      default:    rdata = '0;
    endcase
  end

  assign run   = ctrl_q[RUN_BIT];
  assign flags = flag_q;
endmodule

// File: rtl/pingpong_addr_seq.sv
module pingpong_addr_seq
  import pps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             tick,
  output logic             addr_valid,
  input  logic             addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic             irq
);
  logic              run;
  logic [2:0]        step;
  logic [ADDR_W-1:0] start_a, start_b, position;
  logic [LEN_W-1:0]  len_a, len_b, offset;
  logic [1:0]        done, flags;
  logic              active;

  pps_regs #(.AW(ADDR_W), .LW(LEN_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .done(done), .active(active), .offset(offset),
    .position(position), .run(run), .step(step), .start_a(start_a),
    .start_b(start_b), .len_a(len_a), .len_b(len_b), .flags(flags)
  );

  pps_seq #(.AW(ADDR_W), .LW(LEN_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step), .start_a(start_a),
    .start_b(start_b), .len_a(len_a), .len_b(len_b), .tick(tick),
    .out_ready(addr_ready), .out_valid(addr_valid), .out_addr(addr_out),
    .done(done), .active(active), .offset(offset), .position(position)
  );

  assign irq = |flags;
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        addr_valid,
  input logic        addr_ready,
  input logic [31:0] addr_out,
  input logic        irq,
  input logic        run,
  input logic [1:0]  done,
  input logic        active,
  input logic [15:0] offset
);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_out));

  assert_paused_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !addr_valid |=> !addr_valid);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !reg_wr |=> irq);

  assert_wrap_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    |done |=> offset == 16'd0 && active != $past(active));

  assert_done_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    |done |=> irq);
endmodule

bind pingpong_addr_seq pps_checker chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .addr_valid(addr_valid),
  .addr_ready(addr_ready), .addr_out(addr_out), .irq(irq), .run(run),
  .done(done), .active(active), .offset(offset)
);

// File: tb/pingpong_addr_seq_tb_top.sv
module pingpong_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        tick = 0;
  logic        addr_valid;
  logic        addr_ready = 0;
  logic [31:0] addr_out;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [5:0]  m_ctrl;
  logic [1:0]  m_flags;
  logic [31:0] m_start [2];
  logic [15:0] m_len [2];
  logic        m_act;
  logic [15:0] m_ofs;
  logic        m_valid;
  logic [31:0] m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
    .irq(irq)
  );

  function automatic int step_of(logic [5:0] c);
    if (!c[4] && !c[5]) return 1;
    if (c[4] && c[5]) return 4;
    return 2;
  endfunction

  task automatic check(string req, logic [31:0] actual, logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 0; m_flags = 0; m_act = 0; m_ofs = 0; m_valid = 0; m_addr = 0;
    m_start[0] = 0; m_start[1] = 0; m_len[0] = 0; m_len[1] = 0;
  endtask

  // one clock cycle with the given inputs; model updated, outputs checked
  task automatic cyc(input logic wr, input logic [2:0] idx, input logic [31:0] wd,
                     input logic tk, input logic rdy);
    logic fire;
    logic [1:0] setf;
    logic [1:0] ackf;
    int st;
    reg_wr = wr; reg_addr = idx; reg_wdata = wd; tick = tk; addr_ready = rdy;
    fire = tk && m_ctrl[0] && (!m_valid || rdy);
    setf = 0;
    ackf = (wr && idx == 3'd1) ? wd[2:1] : 2'b00;
    @(posedge clk);
    #1;
    if (m_valid && rdy) m_valid = 0;
    if (fire) begin
      st = step_of(m_ctrl);
      m_valid = 1;
      m_addr = m_start[m_act] + {16'd0, m_ofs};
      if ({1'b0, m_ofs} + 17'(st) >= {1'b0, m_len[m_act]}) begin
        setf[m_act] = 1'b1;
        m_ofs = 0;
        m_act = ~m_act;
      end else begin
        m_ofs = m_ofs + 16'(st);
      end
    end
    m_flags = (m_flags & ~ackf) | setf;
    if (wr) begin
      case (idx)
        3'd0: m_ctrl = wd[5:0];
        3'd2: m_start[0] = wd;
        3'd3: m_start[1] = wd;
        3'd4: begin m_len[0] = wd[15:0]; m_len[1] = wd[31:16]; end
        default: ;
      endcase
    end
    reg_wr = 0; tick = 0;
    check("R6 addr_valid", {31'd0, addr_valid}, {31'd0, m_valid});
    if (m_valid) check("R2 addr_out", addr_out, m_addr);
    check("R8 irq", {31'd0, irq}, {31'd0, |m_flags});
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    cyc(1'b1, idx, d, 1'b0, 1'b1);
  endtask

  task automatic rd_check(string req, input logic [2:0] idx, input logic [31:0] exp);
    reg_addr = idx;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic check_position(string req);
    rd_check(req, 3'd5, m_start[m_act] + {16'd0, m_ofs});
    rd_check(req, 3'd6, {15'd0, m_act, m_ofs});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held_ofs;
    logic held_act;
    void'($urandom(32'd20240613));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    for (int i = 0; i < 7; i++) rd_check("R1 reset reg", 3'(i), 32'd0);
    check("R1 addr_valid", {31'd0, addr_valid}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // configure two areas
    wr(3'd2, 32'h0000_1000);
    wr(3'd3, 32'h0000_2000);
    wr(3'd4, {16'd12, 16'd8});
    rd_check("R10 lengths readback", 3'd4, {16'd12, 16'd8});
    wr(3'd0, 32'h1);
    // R2/R5: byte steps through both areas
    for (int i = 0; i < 30; i++) begin
      cyc(1'b0, 3'd0, 0, 1'b1, 1'b1);
      check_position("R10 position");
    end
    rd_check("R5 both flags", 3'd1, {29'd0, m_flags, 1'b0});
    // R7: clear first flag only
    wr(3'd1, 32'h2);
    rd_check("R7 clear bit1", 3'd1, {29'd0, m_flags, 1'b0});
    wr(3'd1, 32'hFFFF);
    rd_check("R7 clear all", 3'd1, 32'd0);
    check("R8 irq low after ack", {31'd0, irq}, 32'd0);

    // R4: 16-bit mono, then 16-bit stereo, then 8-bit stereo
    wr(3'd0, 32'h11);
    for (int i = 0; i < 12; i++) cyc(1'b0, 3'd0, 0, 1'b1, 1'b1);
    check_position("R4 step2");
    wr(3'd0, 32'h31);
    for (int i = 0; i < 12; i++) cyc(1'b0, 3'd0, 0, 1'b1, 1'b1);
    check_position("R4 step4");
    wr(3'd0, 32'h21);
    for (int i = 0; i < 7; i++) cyc(1'b0, 3'd0, 0, 1'b1, 1'b1);
    check_position("R4 step2 stereo8");

    // R3: pause holds position, resume continues
    held_ofs = m_ofs; held_act = m_act;
    wr(3'd0, 32'h20);
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'd0, 0, 1'b1, 1'b1);
    check("R3 no address while paused", {31'd0, addr_valid}, 32'd0);
    rd_check("R3 held offset", 3'd6, {15'd0, held_act, held_ofs});
    wr(3'd0, 32'h21);
    cyc(1'b0, 3'd0, 0, 1'b1, 1'b1);
    check("R3 resume address", addr_out, m_start[held_act] + {16'd0, held_ofs});

    // R6: stall with ticks arriving
    cyc(1'b0, 3'd0, 0, 1'b1, 1'b0);
    held_ofs = m_ofs;
    for (int i = 0; i < 5; i++) cyc(1'b0, 3'd0, 0, 1'b1, 1'b0);
    rd_check("R6 dropped ticks", 3'd6, {15'd0, m_act, held_ofs});
    cyc(1'b0, 3'd0, 0, 1'b1, 1'b1);

    // R9: read-only zero bits
    wr(3'd0, 32'hFFFF_FFFF);
    rd_check("R9 ctrl upper", 3'd0, 32'h3F);
    wr(3'd0, 32'h01);
    wr(3'd1, 32'hFFFF_FFFF);
    rd_check("R9 status others", 3'd1, 32'd0);

    // R5: zero-length areas finish every tick
    wr(3'd4, 32'd0);
    cyc(1'b0, 3'd0, 0, 1'b1, 1'b1);
    cyc(1'b0, 3'd0, 0, 1'b1, 1'b1);
    rd_check("R5 zero length flags", 3'd1, 32'h6);
    wr(3'd1, 32'h4);
    rd_check("R7 clear bit2 only", 3'd1, {29'd0, m_flags, 1'b0});

    // random mix
    wr(3'd4, {16'd20, 16'd10});
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3)
        cyc(1'b1, 3'd1, {29'd0, 2'($urandom), 1'b0}, $urandom_range(0, 1) == 1, 1'b1);
      else if (r < 5)
        cyc(1'b1, 3'd0, {26'd0, 2'($urandom), 3'd0, ($urandom_range(0, 3) != 0)}, 1'b0, 1'b1);
      else
        cyc(1'b0, 3'd0, 0, $urandom_range(0, 2) != 0, $urandom_range(0, 3) != 0);
      if (i % 50 == 0) begin
        check_position("R10 random position");
        rd_check("R7 random status", 3'd1, {29'd0, m_flags, 1'b0});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule